// File: doc/BRIEF.md
# Banked RAM Card Soft-Switch Controller

This controller maps 16 KB of extra RAM into the top 12 KB of a 16-bit address space on an 8-bit CPU bus. That part of the address space normally holds a ROM. Sixteen soft-switch addresses, 0xC080 to 0xC08F, form a small I/O window. Touching any of them changes the mapping state: the access is what counts, and any data on the bus is ignored.

The mapping state has three parts:
- which of two 4 KB banks appears at 0xD000–0xDFFF;
- whether reads in 0xD000–0xFFFF go to RAM or to ROM;
- whether CPU writes reach RAM.

The 0xE000–0xFFFF range always goes to one 8 KB RAM region. Write enable is protected by an unlock sequence. Two odd soft-switch reads must come before it, with no other soft-switch access between them.

The unlock sequence is held in a three-state machine:
- `UNLK_IDLE`: no qualifying read has been seen.
- `UNLK_ONE`: one odd read has been seen.
- `UNLK_ARMED`: two or more odd reads have been seen, and write enable is set.

The transitions are:
- *odd read*: `UNLK_IDLE` → `UNLK_ONE` → `UNLK_ARMED`, and `UNLK_ARMED` stays in `UNLK_ARMED`.
- *even access*, read or write: every state goes to `UNLK_IDLE`.
- *odd write*: every state goes to `UNLK_IDLE`.

Accesses outside the soft-switch window leave the machine where it is. The outputs are RAM and ROM chip selects, a bank bit for the RAM, and a RAM write strobe. All outputs are combinational from the bus strobe, the address and the registered state.

Top module: `bank_card_ctrl`

## Requirements
- R1: After reset, RAM read and RAM write are disabled, the unlock machine is in `UNLK_IDLE`, and bank 2 is selected (bank bit 0). As a result, a read at 0xF800–0xFFFF asserts only `rom_cs`, and reads at 0xD000–0xF7FF select nothing.
- R2: Only a strobed access with an address in 0xC080–0xC08F changes the mapping state. Any other access, or a cycle without the strobe, leaves the state unchanged.
- R3: Every soft-switch access selects the 0xD000–0xDFFF bank from its address bit 3. Bit 3 = 1 selects bank 1, and the bank bit goes high. Bit 3 = 0 selects bank 2, and the bank bit goes low.
- R4: A soft-switch access with address bits [1:0] = 00 enables RAM read, disables RAM write and returns the machine to `UNLK_IDLE`. This holds for reads and for writes.
- R5: A soft-switch read with bits [1:0] = 01 disables RAM read and advances the unlock machine. RAM write becomes enabled when the machine reaches `UNLK_ARMED`. Further odd reads keep it armed and never wrap. Accesses outside the window between the two reads do not break the sequence.
- R6: A soft-switch read with bits [1:0] = 11 enables RAM read and advances the unlock machine in the same way as R5.
- R7: A soft-switch access with bits [1:0] = 10 disables both RAM read and RAM write and returns the machine to `UNLK_IDLE`.
- R8: A soft-switch write with bits [1:0] = 01 or 11 returns the machine to `UNLK_IDLE` and never sets write enable. It leaves write enable as it was. It still applies read disable (for 01) or read enable (for 11).
- R9: A strobed read in 0xD000–0xFFFF asserts `ram_cs` when RAM read is enabled. Otherwise a read in 0xF800–0xFFFF asserts `rom_cs`, and a read elsewhere in the range asserts nothing.
- R10: A strobed write in 0xD000–0xFFFF asserts `ram_cs` and `ram_we` only when RAM write is enabled. Otherwise the write is dropped. `rom_cs` is never asserted on a write.
- R11: An access outside 0xC080–0xC08F and 0xD000–0xFFFF asserts no select. This includes soft-switch accesses themselves and cycles without the strobe.
- R12: `ram_bank` is high only while `ram_cs` selects 0xD000–0xDFFF with bank 1 mapped. It is low for 0xE000–0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = CPU write, 0 = CPU read |
| bus_addr | input | 16 | CPU address |
| ram_cs | output | 1 | RAM chip select |
| rom_cs | output | 1 | ROM chip select (0xF800–0xFFFF) |
| ram_bank | output | 1 | Bank bit for RAM: 1 = bank 1 in 0xD000–0xDFFF |
| ram_we | output | 1 | RAM write strobe |

## Verification
A behavioural reference model tracks read enable, write enable, the unlock count and the bank, and is compared with all four outputs on every clock.

Reads are tried in several patterns:
- Single odd reads, which must not arm writes. This separates a one-step unlock from the required two-step unlock.
- Back-to-back odd reads and runs of three or more, which check arming and that the count does not wrap.
- Odd reads with unrelated memory traffic between them, which confirms that only soft-switch accesses reset the sequence.

Writes to the soft-switch window are placed inside an unlock sequence. This separates "every soft-switch access counts" from "only reads count". The same writes also show that a write keeps the read-enable setting its address calls for.

Each memory access is repeated with bank 1 and with bank 2 selected, and with RAM read on and off. This shows bank-bit routing and the RAM/ROM fallback at the 0xF7FF/0xF800 edge.

// File: rtl/bank_card_pkg.sv
package bank_card_pkg;

    typedef enum logic [1:0] {
        UNLK_IDLE  = 2'd0,
        UNLK_ONE   = 2'd1,
        UNLK_ARMED = 2'd2
    } unlk_state_t;

    // low two address bits of a soft-switch access
    typedef enum logic [1:0] {
        SW_RD_ON   = 2'b00,
        SW_ODD_OFF = 2'b01,
        SW_ALL_OFF = 2'b10,
        SW_ODD_ON  = 2'b11
    } sw_code_t;

    typedef struct packed {
        logic sw;     // soft-switch window
        logic lo;     // banked 4 KB window
        logic hi;     // fixed 8 KB window
        logic rom;    // ROM overlay range
    } addr_class_t;

endpackage

// File: rtl/bank_card_decode.sv
module bank_card_decode
    import bank_card_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] SW_BASE  = 16'hC080,
    parameter int          SW_SPAN  = 16,
    parameter logic [15:0] LO_BASE  = 16'hD000,
    parameter int          LO_SPAN  = 4096,
    parameter logic [15:0] ROM_BASE = 16'hF800
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_t       cls
);
    localparam logic [ADDR_W:0] SW_END = {1'b0, SW_BASE} + SW_SPAN[ADDR_W:0];
    localparam logic [ADDR_W:0] LO_END = {1'b0, LO_BASE} + LO_SPAN[ADDR_W:0];

    logic [ADDR_W:0] a;

    always_comb begin
        a       = {1'b0, addr};
        cls.sw  = (a >= {1'b0, SW_BASE}) && (a < SW_END);
        cls.lo  = (a >= {1'b0, LO_BASE}) && (a < LO_END);
        cls.hi  = (a >= LO_END);
        cls.rom = (a >= {1'b0, ROM_BASE});
    end

endmodule

// File: rtl/bank_card_unlock.sv
module bank_card_unlock
    import bank_card_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_stb,
    input  logic       sw_we,
    input  logic [1:0] sw_low,
    input  logic       sw_bank,
    output logic       rd_en,
    output logic       wr_en,
    output logic       bank1
);
    unlk_state_t state, state_n;
    logic        rd_n, wr_n, bank_n;

    // next-state and flag logic
    always_comb begin
        state_n = state;
        rd_n    = rd_en;
        wr_n    = wr_en;
        bank_n  = bank1;
        if (sw_stb) begin
            bank_n = sw_bank;
            unique case (sw_code_t'(sw_low))
                SW_RD_ON: begin
                    rd_n    = 1'b1;
                    wr_n    = 1'b0;
                    state_n = UNLK_IDLE;
                end
                SW_ALL_OFF: begin
                    rd_n    = 1'b0;
                    wr_n    = 1'b0;
                    state_n = UNLK_IDLE;
                end
                SW_ODD_OFF, SW_ODD_ON: begin
                    rd_n = sw_low[1];
                    if (sw_we) begin
                        state_n = UNLK_IDLE;
                    end else begin
                        unique case (state)
                            UNLK_IDLE:  state_n = UNLK_ONE;
                            UNLK_ONE: begin
                                state_n = UNLK_ARMED;
                                wr_n    = 1'b1;
                            end
                            UNLK_ARMED: begin
                                state_n = UNLK_ARMED;
                                wr_n    = 1'b1;
                            end
                            default:    state_n = UNLK_IDLE;
                        endcase
                    end
                end
                default: state_n = UNLK_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= UNLK_IDLE;
            rd_en <= 1'b0;
            wr_en <= 1'b0;
            bank1 <= 1'b0;
        end else begin
            state <= state_n;
            rd_en <= rd_n;
            wr_en <= wr_n;
            bank1 <= bank_n;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_en && !wr_en && !bank1 && state == UNLK_IDLE));

    a_r2_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_stb |=> ($stable(rd_en) && $stable(wr_en) && $stable(bank1)));

    a_r3_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stb |=> (bank1 == $past(sw_bank)));

    a_r4_even_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && sw_low == 2'b00) |=> (rd_en && !wr_en && state == UNLK_IDLE));

    a_r5_arm_second: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && !sw_we && sw_low[0] && state != UNLK_IDLE) |=> (wr_en && state == UNLK_ARMED));

    a_r5_single_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && !sw_we && sw_low[0] && state == UNLK_IDLE && !wr_en) |=> !wr_en);

    a_r7_lock_all: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && sw_low == 2'b10) |=> (!rd_en && !wr_en && state == UNLK_IDLE));

    a_r8_write_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && sw_we && sw_low[0]) |=> (state == UNLK_IDLE && wr_en == $past(wr_en)
                                             && rd_en == $past(sw_low[1])));

endmodule

// File: rtl/bank_card_ctrl.sv
module bank_card_ctrl
    import bank_card_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              ram_bank,
    output logic              ram_we
);
    localparam int BANK_BIT = 3;

    addr_class_t cls;
    logic        rd_en, wr_en, bank1;
    logic        mem_hit;

    bank_card_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .cls  (cls)
    );

    bank_card_unlock u_unlk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_stb  (bus_stb && cls.sw),
        .sw_we   (bus_we),
        .sw_low  (bus_addr[1:0]),
        .sw_bank (bus_addr[BANK_BIT]),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .bank1   (bank1)
    );

    // output selection
    always_comb begin
        mem_hit  = bus_stb && (cls.lo || cls.hi);
        ram_cs   = 1'b0;
        rom_cs   = 1'b0;
        ram_we   = 1'b0;
        if (mem_hit) begin
            if (bus_we) begin
                ram_cs = wr_en;
                ram_we = wr_en;
            end else if (rd_en) begin
                ram_cs = 1'b1;
            end else begin
                rom_cs = cls.rom;
            end
        end
        ram_bank = ram_cs && cls.lo && bank1;
    end

    a_r10_rom_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_we) |-> !rom_cs);

    a_r11_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_stb || !(cls.lo || cls.hi)) |-> (!ram_cs && !rom_cs && !ram_we));

    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_cs, rom_cs}) <= 1);

    a_r12_bank_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && cls.hi) |-> !ram_bank);

endmodule

// File: tb/bank_card_ctrl_tb.sv
module bank_card_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        ram_cs, rom_cs, ram_bank, ram_we;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string req   = "R1";

    // reference model state
    int m_rd = 0, m_wr = 0, m_cnt = 0, m_bank = 0;

    always #5 clk = ~clk;

    bank_card_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .ram_cs(ram_cs), .rom_cs(rom_cs),
        .ram_bank(ram_bank), .ram_we(ram_we)
    );

    task automatic cyc(input bit v, input bit we, input int a);
        bit sw, lo, hi, rm;
        bit e_ram, e_rom, e_bank, e_we;
        @(negedge clk);
        bus_stb  = v;
        bus_we   = we;
        bus_addr = a[15:0];
        sw = (a >= 'hC080 && a <= 'hC08F);
        lo = (a >= 'hD000 && a <= 'hDFFF);
        hi = (a >= 'hE000 && a <= 'hFFFF);
        rm = (a >= 'hF800 && a <= 'hFFFF);
        e_ram = 0; e_rom = 0; e_bank = 0; e_we = 0;
        if (v && (lo || hi)) begin
            if (we) begin
                if (m_wr != 0) begin e_ram = 1; e_we = 1; end
            end else if (m_rd != 0) e_ram = 1;
            else if (rm) e_rom = 1;
            if (e_ram && lo && m_bank != 0) e_bank = 1;
        end
        #3;
        n_vec++;
        if ({ram_cs, rom_cs, ram_bank, ram_we} !== {e_ram, e_rom, e_bank, e_we}) begin
            n_bad++;
            $display("FAIL %s stb=%0b we=%0b addr=%h: got cs/rom/bank/we=%b%b%b%b expected %b%b%b%b",
                     req, v, we, a[15:0], ram_cs, rom_cs, ram_bank, ram_we,
                     e_ram, e_rom, e_bank, e_we);
        end
        @(posedge clk);
        if (v && sw) begin
            m_bank = (a & 8) != 0 ? 1 : 0;
            case (a & 3)
                0: begin m_rd = 1; m_wr = 0; m_cnt = 0; end
                2: begin m_rd = 0; m_wr = 0; m_cnt = 0; end
                default: begin
                    m_rd = ((a & 2) != 0) ? 1 : 0;
                    if (we) m_cnt = 0;
                    else begin
                        if (m_cnt < 2) m_cnt++;
                        if (m_cnt >= 2) m_wr = 1;
                    end
                end
            endcase
        end
    endtask

    task automatic rd(input int a); cyc(1, 0, a); endtask
    task automatic wr(input int a); cyc(1, 1, a); endtask

    // probe every mapped region with reads and writes
    task automatic probe();
        rd('hD000); rd('hDFFF); rd('hE000); rd('hF7FF); rd('hF800); rd('hFFFF);
        wr('hD123); wr('hE456); wr('hFABC);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; R9/R10 fallback to ROM, writes dropped
        req = "R1"; cyc(0, 0, 'hD000); probe();
        // R11: outside windows and idle cycles
        req = "R11";
        rd('h0000); wr('hC07F); rd('hC090); wr('hCFFF); cyc(0, 1, 'hE000); cyc(0, 0, 'hF800);
        // R2: non-switch traffic leaves state alone
        req = "R2"; wr('hC07F); rd('hC090); probe();
        // R4: even access enables read, bank 2
        req = "R4"; rd('hC080); probe();
        // R3/R12: bank 1 via bit 3
        req = "R3"; rd('hC08C); probe();
        req = "R12"; rd('hC084); rd('hD800); rd('hE800);
        // R5: single odd read does not arm
        req = "R5"; rd('hC081); probe();
        rd('hC081); probe();
        rd('hC089); rd('hC089); rd('hC081); probe();   // saturation, no wrap
        // R4 clears write enable
        req = "R4"; wr('hC084); probe();
        // R5: unrelated traffic between odd reads
        req = "R5"; rd('hC081); rd('hD000); cyc(0, 0, 0); wr('hE000); rd('hC085); probe();
        // R7: lock all
        req = "R7"; rd('hC08A); probe();
        // R6: odd-on reads
        req = "R6"; rd('hC083); probe(); rd('hC08B); probe();
        // R8: switch writes reset the count and keep write enable
        req = "R8"; wr('hC081); probe(); wr('hC08B); probe();
        rd('hC086);
        rd('hC083); wr('hC083); rd('hC083); probe();
        rd('hC08B); probe();
        rd('hC082); rd('hC081); wr('hC089); probe(); rd('hC081); probe();
        // R10: ROM never written even with RAM write off
        req = "R10"; rd('hC080); wr('hF800); wr('hFFFF); rd('hFFFF);
        // R9: read disabled with write enabled reads ROM
        req = "R9"; rd('hC081); rd('hC081); probe();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule